// File: doc/BRIEF.md
# Command Slot Fetch and Decode Engine

This engine walks the pending command slots of a storage host controller and turns each one into a transfer request. When it gets a processing request, it visits the ports in ascending order. Within a port it takes the set command issue bits lowest index first. For each slot it reads two words of the 32-byte slot header from system memory: the options word and the command table pointer. It then reads the leading words of the host-to-device register frame held in that table.

The engine decodes the frame into a 24-bit block address, a byte count and a direction. It hands these to a data mover, along with the location and length of the scatter list. After the data mover signals completion, the engine retires the slot. Retiring clears the slot's issue bit and sets the port's completion flag, which feeds a single interrupt line. Commands the engine cannot handle are retired at once with a one-cycle fault flag and no transfer.

Memory is read one 32-bit word at a time through a request/acknowledge master. Software-side register access is outside the block: issue bits arrive through a set strobe, and list base addresses arrive as plain inputs.

Top module: `cmd_slot_engine`

## Requirements
- R1: After reset all issue bits, completion flags, `irq`, `busy`, `mem_req`, `mv_valid` and `retire_pulse` are 0.
- R2: For slot n of port p the first two memory reads go to list_base[p] + 32·n (options word) and list_base[p] + 32·n + 8 (table pointer). Any frame reads follow from the table pointer upward in 4-byte steps.
- R3: The number of frame words read is min(options[4:0], 4). Frame bytes that are not read count as zero, so a 3-word frame always yields sector count 0.
- R4: With frame byte0 = 0x27 and byte1 = 0x80, command byte2 = 0xC8 requests a transfer to memory (`mv_write`=0) and 0xCA a transfer to the disk (`mv_write`=1). The LBA is {byte6, byte5, byte4} and `mv_bytes` is count×512, where the count is {byte13, byte12} and a count of 0 stands for 256. Bytes are taken little-endian from each word.
- R5: Command 0xEC requests a 512-byte transfer to memory.
- R6: Command 0xEF, and any frame with byte0 = 0x27 whose byte1 is not 0x80, is retired with no `mv_valid` and `bad_cmd`=0.
- R7: The transfer request carries scatter-list address = table pointer + 0x80 and entry count = options[31:16].
- R8: A frame whose byte0 is not 0x27, or a command frame whose code is none of the four above, is retired with `bad_cmd`=1 during `retire_pulse` and with no `mv_valid`.
- R9: Slots retire one at a time: port 0 before port 1, lower slot before higher. A processing request with no issued bits returns the engine to idle with no memory read.
- R10: In the cycle after `retire_pulse` the slot's issue bit is 0 and the port's completion flag is 1. `irq` is the OR over ports of flag AND `irq_en`. A pulse on `irq_clr[p]` clears flag p.
- R11: `mv_valid` stays high with unchanged fields until `mv_done`. The slot retires in the following cycle.
- R12: `mem_req` stays high with an unchanged `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Processing request pulse |
| busy | output | 1 | Engine is walking slots |
| issue_set_en | input | 1 | Strobe to set issue bits |
| issue_set_port | input | PW | Port addressed by the strobe |
| issue_set_bits | input | NSLOTS | Issue bits to OR in |
| issue_bits | output | NPORTS·NSLOTS | Issue bits, port p at [p·NSLOTS +: NSLOTS] |
| list_base | input | NPORTS·AW | Slot list base per port |
| irq_en | input | NPORTS | Per-port interrupt enable |
| irq_clr | input | NPORTS | Per-port completion flag clear |
| irq_stat | output | NPORTS | Per-port completion flag |
| irq | output | 1 | Interrupt roll-up |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Byte address of the word |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mv_valid | output | 1 | Transfer request valid |
| mv_write | output | 1 | 1: memory to disk |
| mv_lba | output | 24 | Block address |
| mv_bytes | output | 25 | Transfer length in bytes |
| mv_prdt_addr | output | AW | Scatter list address |
| mv_prdt_cnt | output | 16 | Scatter list entries |
| mv_port | output | PW | Port of the request |
| mv_slot | output | SW | Slot of the request |
| mv_done | input | 1 | Data mover finished |
| retire_pulse | output | 1 | Slot retires this cycle |
| retire_port | output | PW | Port being retired |
| retire_slot | output | SW | Slot being retired |
| bad_cmd | output | 1 | Retired slot was unsupported |

## Verification
The main decode path is exercised with a table of slot images. Some of these only the command code tells apart: read DMA, write DMA, identify, set features and an unknown code. Others differ from a valid frame only in the frame type byte or the command marker byte. Frame lengths of 0, 3, 5 and 16 words show that exactly min(length,4) words are fetched and that missing bytes read as zero: a count held in memory beyond a 3-word frame must give 256 sectors, and an empty frame must fault even though memory holds a valid one. Counts of 0, 8 and 0xFFFF, together with LBAs at both extremes, separate the zero-means-256 rule from plain multiplication. A mixed issue pattern across both ports pins down the retire order.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int WORD_W        = 32;
    localparam int HDR_SHIFT     = 5;    // 32-byte slot headers
    localparam int TBL_LIST_OFS  = 'h80; // scatter list offset in table
    localparam int FIS_WORDS_MAX = 4;
    localparam int LBA_W         = 24;
    localparam int BYTES_W       = 25;

    localparam logic [7:0] FIS_TYPE_H2D = 8'h27;
    localparam logic [7:0] FIS_MARK_CMD = 8'h80;
    localparam logic [7:0] OP_READ_DMA  = 8'hC8;
    localparam logic [7:0] OP_WRITE_DMA = 8'hCA;
    localparam logic [7:0] OP_IDENTIFY  = 8'hEC;
    localparam logic [7:0] OP_SET_FEAT  = 8'hEF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SCAN, ST_HDR0, ST_HDR2, ST_FIS, ST_DEC, ST_MOVE, ST_RET
    } eng_state_e;

    typedef enum logic [1:0] {
        ACT_NONE, ACT_XFER, ACT_FAULT
    } cmd_act_e;

    typedef struct packed {
        cmd_act_e            act;
        logic                to_disk;
        logic [LBA_W-1:0]    lba;
        logic [BYTES_W-1:0]  nbytes;
    } cmd_dec_t;

    function automatic logic [BYTES_W-1:0] sect_bytes(input logic [15:0] cnt);
        logic [15:0] s;
        s = (cnt == 16'd0) ? 16'd256 : cnt;
        return {s, 9'b0};
    endfunction

    function automatic logic [2:0] fis_word_count(input logic [4:0] flen);
        return (flen > 5'd4) ? 3'd4 : flen[2:0];
    endfunction

endpackage

// File: rtl/cse_slot_pick.sv
module cse_slot_pick #(
    parameter int NSLOTS = 32,
    localparam int SW    = $clog2(NSLOTS)
) (
    input  logic [NSLOTS-1:0] bits,
    input  logic [SW:0]       cursor,
    output logic              found,
    output logic [SW-1:0]     idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            if (bits[i] && (i >= int'(cursor))) begin
                found = 1'b1;
                idx   = SW'(i);
            end
        end
    end
endmodule

// File: rtl/cse_issue_bank.sv
module cse_issue_bank #(
    parameter int NPORTS = 2,
    parameter int NSLOTS = 32,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int SW    = $clog2(NSLOTS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_en,
    input  logic [PW-1:0]            set_port,
    input  logic [NSLOTS-1:0]        set_bits,
    input  logic                     ret_en,
    input  logic [PW-1:0]            ret_port,
    input  logic [SW-1:0]            ret_slot,
    input  logic [NPORTS-1:0]        flag_clr,
    output logic [NPORTS*NSLOTS-1:0] issue,
    output logic [NPORTS-1:0]        flag
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [NSLOTS-1:0] clr_mask, add_mask;
        logic              hit;

        always_comb begin
            hit      = ret_en && (ret_port == PW'(p));
            clr_mask = hit ? (NSLOTS'(1) << ret_slot) : '0;
            add_mask = (set_en && (set_port == PW'(p))) ? set_bits : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                issue[p*NSLOTS +: NSLOTS] <= '0;
                flag[p]                   <= 1'b0;
            end else begin
                issue[p*NSLOTS +: NSLOTS] <= (issue[p*NSLOTS +: NSLOTS] & ~clr_mask) | add_mask;
                if (hit)
                    flag[p] <= 1'b1;
                else if (flag_clr[p])
                    flag[p] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cse_fis_decode.sv
module cse_fis_decode
    import cse_pkg::*;
(
    input  logic [FIS_WORDS_MAX*WORD_W-1:0] fis,
    output cmd_dec_t                        dec
);
    logic [7:0] b0, b1, b2, b4, b5, b6, b12, b13;
    logic       unused_bytes;

    assign b0  = fis[0*8 +: 8];
    assign b1  = fis[1*8 +: 8];
    assign b2  = fis[2*8 +: 8];
    assign b4  = fis[4*8 +: 8];
    assign b5  = fis[5*8 +: 8];
    assign b6  = fis[6*8 +: 8];
    assign b12 = fis[12*8 +: 8];
    assign b13 = fis[13*8 +: 8];
    assign unused_bytes = ^{fis[3*8 +: 8], fis[7*8 +: 40], fis[14*8 +: 16]};

    always_comb begin
        dec.act     = ACT_FAULT;
        dec.to_disk = 1'b0;
        dec.lba     = {b6, b5, b4};
        dec.nbytes  = '0;
        if (b0 != FIS_TYPE_H2D) begin
            dec.act = ACT_FAULT;
        end else if (b1 != FIS_MARK_CMD) begin
            dec.act = ACT_NONE;
        end else begin
            case (b2)
                OP_READ_DMA: begin
                    dec.act    = ACT_XFER;
                    dec.nbytes = sect_bytes({b13, b12});
                end
                OP_WRITE_DMA: begin
                    dec.act     = ACT_XFER;
                    dec.to_disk = 1'b1;
                    dec.nbytes  = sect_bytes({b13, b12});
                end
                OP_IDENTIFY: begin
                    dec.act    = ACT_XFER;
                    dec.nbytes = BYTES_W'(512);
                end
                OP_SET_FEAT: dec.act = ACT_NONE;
                default:     dec.act = ACT_FAULT;
            endcase
        end
    end
endmodule

// File: rtl/cmd_slot_engine.sv
module cmd_slot_engine
    import cse_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int NSLOTS = 32,
    parameter int AW     = 32,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int SW    = $clog2(NSLOTS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic                     busy,
    input  logic                     issue_set_en,
    input  logic [PW-1:0]            issue_set_port,
    input  logic [NSLOTS-1:0]        issue_set_bits,
    output logic [NPORTS*NSLOTS-1:0] issue_bits,
    input  logic [NPORTS*AW-1:0]     list_base,
    input  logic [NPORTS-1:0]        irq_en,
    input  logic [NPORTS-1:0]        irq_clr,
    output logic [NPORTS-1:0]        irq_stat,
    output logic                     irq,
    output logic                     mem_req,
    output logic [AW-1:0]            mem_addr,
    input  logic                     mem_ack,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     mv_valid,
    output logic                     mv_write,
    output logic [LBA_W-1:0]         mv_lba,
    output logic [BYTES_W-1:0]       mv_bytes,
    output logic [AW-1:0]            mv_prdt_addr,
    output logic [15:0]              mv_prdt_cnt,
    output logic [PW-1:0]            mv_port,
    output logic [SW-1:0]            mv_slot,
    input  logic                     mv_done,
    output logic                     retire_pulse,
    output logic [PW-1:0]            retire_port,
    output logic [SW-1:0]            retire_slot,
    output logic                     bad_cmd
);
    localparam int FIS_W = FIS_WORDS_MAX * WORD_W;

    eng_state_e        state;
    logic [PW-1:0]     port_q;
    logic [SW:0]       cursor;
    logic [SW-1:0]     slot_q;
    logic [4:0]        flen_q;
    logic [15:0]       prdt_q;
    logic [AW-1:0]     tbl_q;
    logic [FIS_W-1:0]  fis_q;
    logic [2:0]        fidx;
    logic [2:0]        fis_words;
    cmd_dec_t          dec_w, dec_q;
    logic              pick_found;
    logic [SW-1:0]     pick_idx;
    logic [AW-1:0]     hdr_addr;
    logic              unused_hdr;

    assign unused_hdr = ^mem_rdata[15:5];

    cse_issue_bank #(.NPORTS(NPORTS), .NSLOTS(NSLOTS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_en   (issue_set_en),
        .set_port (issue_set_port),
        .set_bits (issue_set_bits),
        .ret_en   (retire_pulse),
        .ret_port (port_q),
        .ret_slot (slot_q),
        .flag_clr (irq_clr),
        .issue    (issue_bits),
        .flag     (irq_stat)
    );

    cse_slot_pick #(.NSLOTS(NSLOTS)) u_pick (
        .bits   (issue_bits[port_q*NSLOTS +: NSLOTS]),
        .cursor (cursor),
        .found  (pick_found),
        .idx    (pick_idx)
    );

    cse_fis_decode u_dec (
        .fis (fis_q),
        .dec (dec_w)
    );

    assign fis_words = fis_word_count(flen_q);
    assign hdr_addr  = list_base[port_q*AW +: AW] + (AW'(slot_q) << HDR_SHIFT);

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = hdr_addr;
        case (state)
            ST_HDR0: mem_req = 1'b1;
            ST_HDR2: begin
                mem_req  = 1'b1;
                mem_addr = hdr_addr + AW'(8);
            end
            ST_FIS: begin
                mem_req  = (fidx != fis_words);
                mem_addr = tbl_q + (AW'(fidx) << 2);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            port_q <= '0;
            cursor <= '0;
            slot_q <= '0;
            flen_q <= '0;
            prdt_q <= '0;
            tbl_q  <= '0;
            fis_q  <= '0;
            fidx   <= '0;
            dec_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    port_q <= '0;
                    cursor <= '0;
                    state  <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (pick_found) begin
                        slot_q <= pick_idx;
                        fis_q  <= '0;
                        state  <= ST_HDR0;
                    end else if (port_q == PW'(NPORTS - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        port_q <= port_q + 1'b1;
                        cursor <= '0;
                    end
                end
                ST_HDR0: if (mem_ack) begin
                    flen_q <= mem_rdata[4:0];
                    prdt_q <= mem_rdata[31:16];
                    state  <= ST_HDR2;
                end
                ST_HDR2: if (mem_ack) begin
                    tbl_q <= mem_rdata[AW-1:0];
                    fidx  <= '0;
                    state <= ST_FIS;
                end
                ST_FIS: begin
                    if (fidx == fis_words) begin
                        state <= ST_DEC;
                    end else if (mem_ack) begin
                        fis_q[32*fidx +: 32] <= mem_rdata;
                        fidx <= fidx + 3'd1;
                    end
                end
                ST_DEC: begin
                    dec_q <= dec_w;
                    state <= (dec_w.act == ACT_XFER) ? ST_MOVE : ST_RET;
                end
                ST_MOVE: if (mv_done) state <= ST_RET;
                ST_RET: begin
                    cursor <= {1'b0, slot_q} + 1'b1;
                    state  <= ST_SCAN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state != ST_IDLE);
    assign irq          = |(irq_stat & irq_en);
    assign mv_valid     = (state == ST_MOVE);
    assign mv_write     = dec_q.to_disk;
    assign mv_lba       = dec_q.lba;
    assign mv_bytes     = dec_q.nbytes;
    assign mv_prdt_addr = tbl_q + AW'(TBL_LIST_OFS);
    assign mv_prdt_cnt  = prdt_q;
    assign mv_port      = port_q;
    assign mv_slot      = slot_q;
    assign retire_pulse = (state == ST_RET);
    assign retire_port  = port_q;
    assign retire_slot  = slot_q;
    assign bad_cmd      = (state == ST_RET) && (dec_q.act == ACT_FAULT);

endmodule

// File: rtl/cmd_slot_engine_chk.sv
module cmd_slot_engine_chk #(
    parameter int NPORTS = 2,
    parameter int NSLOTS = 32,
    parameter int AW     = 32,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int SW    = $clog2(NSLOTS)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     mem_req,
    input logic                     mem_ack,
    input logic [AW-1:0]            mem_addr,
    input logic                     mv_valid,
    input logic                     mv_done,
    input logic                     mv_write,
    input logic [23:0]              mv_lba,
    input logic [24:0]              mv_bytes,
    input logic                     retire_pulse,
    input logic [PW-1:0]            retire_port,
    input logic [SW-1:0]            retire_slot,
    input logic                     issue_set_en,
    input logic [NPORTS*NSLOTS-1:0] issue_bits,
    input logic [NPORTS-1:0]        irq_stat,
    input logic                     irq
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));  // R12

    AST_MV_HOLD: assert property (@(posedge clk) disable iff (rst)
        mv_valid && !mv_done |=> mv_valid && $stable(mv_lba) && $stable(mv_bytes) && $stable(mv_write));  // R11

    AST_RETIRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        retire_pulse && !issue_set_en |=> !issue_bits[int'($past(retire_port)) * NSLOTS + int'($past(retire_slot))]);  // R10

    AST_RETIRE_FLAG: assert property (@(posedge clk) disable iff (rst)
        retire_pulse |=> irq_stat[$past(retire_port)]);  // R10

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irq_stat == '0) |-> !irq);  // R10

    AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (rst)
        retire_pulse |=> !retire_pulse);  // R9
endmodule

bind cmd_slot_engine cmd_slot_engine_chk #(.NPORTS(NPORTS), .NSLOTS(NSLOTS), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .mv_valid     (mv_valid),
    .mv_done      (mv_done),
    .mv_write     (mv_write),
    .mv_lba       (mv_lba),
    .mv_bytes     (mv_bytes),
    .retire_pulse (retire_pulse),
    .retire_port  (retire_port),
    .retire_slot  (retire_slot),
    .issue_set_en (issue_set_en),
    .issue_bits   (issue_bits),
    .irq_stat     (irq_stat),
    .irq          (irq)
);

// File: tb/cmd_slot_engine_bench.sv
`timescale 1ns/1ps
module cmd_slot_engine_bench;
    localparam int NP = 2;
    localparam int NS = 32;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            start = 1'b0;
    logic            busy;
    logic            issue_set_en = 1'b0;
    logic [0:0]      issue_set_port = '0;
    logic [NS-1:0]   issue_set_bits = '0;
    logic [NP*NS-1:0] issue_bits;
    logic [NP*AW-1:0] list_base = {32'h0000_0400, 32'h0000_0000};
    logic [NP-1:0]   irq_en = 2'b01;
    logic [NP-1:0]   irq_clr = '0;
    logic [NP-1:0]   irq_stat;
    logic            irq;
    logic            mem_req;
    logic [AW-1:0]   mem_addr;
    logic            mem_ack;
    logic [31:0]     mem_rdata;
    logic            mv_valid, mv_write;
    logic [23:0]     mv_lba;
    logic [24:0]     mv_bytes;
    logic [AW-1:0]   mv_prdt_addr;
    logic [15:0]     mv_prdt_cnt;
    logic [0:0]      mv_port;
    logic [4:0]      mv_slot;
    logic            mv_done = 1'b0;
    logic            retire_pulse;
    logic [0:0]      retire_port;
    logic [4:0]      retire_slot;
    logic            bad_cmd;

    cmd_slot_engine #(.NPORTS(NP), .NSLOTS(NS), .AW(AW)) u_cmd_slot_engine (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .issue_set_en(issue_set_en), .issue_set_port(issue_set_port),
        .issue_set_bits(issue_set_bits), .issue_bits(issue_bits),
        .list_base(list_base), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq_stat(irq_stat), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_valid(mv_valid), .mv_write(mv_write), .mv_lba(mv_lba), .mv_bytes(mv_bytes),
        .mv_prdt_addr(mv_prdt_addr), .mv_prdt_cnt(mv_prdt_cnt),
        .mv_port(mv_port), .mv_slot(mv_slot), .mv_done(mv_done),
        .retire_pulse(retire_pulse), .retire_port(retire_port),
        .retire_slot(retire_slot), .bad_cmd(bad_cmd)
    );

    // word memory with one-cycle acknowledge and an address log
    logic [31:0] mem [1024];
    logic [31:0] rd_log [8];
    int          rd_n;
    logic        log_clr = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            rd_n    <= 0;
        end else begin
            if (log_clr) rd_n <= 0;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[11:2]];
                if (!log_clr) begin
                    if (rd_n < 8) rd_log[rd_n] <= mem_addr;
                    rd_n <= rd_n + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 retire without transfer, 1 transfer, 2 fault
    typedef struct packed {
        logic [0:0]  port;
        logic [4:0]  slot;
        logic [4:0]  flen;
        logic [15:0] prdt;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [23:0] lba;
        logic [15:0] cnt;
        logic [1:0]  kind;
        logic        wr;
        logic [24:0] nbytes;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd0,  5'd5,  16'd3, 8'h27, 8'h80, 8'hC8, 24'h123456, 16'd8,      2'd1, 1'b0, 25'h0001000},
        '{1'b0, 5'd3,  5'd5,  16'd1, 8'h27, 8'h80, 8'hCA, 24'h000010, 16'd0,      2'd1, 1'b1, 25'h0020000},
        '{1'b1, 5'd7,  5'd5,  16'd1, 8'h27, 8'h80, 8'hEC, 24'h000000, 16'd0,      2'd1, 1'b0, 25'h0000200},
        '{1'b1, 5'd31, 5'd5,  16'd0, 8'h27, 8'h80, 8'hEF, 24'h000000, 16'd0,      2'd0, 1'b0, 25'h0},
        '{1'b0, 5'd1,  5'd3,  16'd2, 8'h27, 8'h80, 8'hC8, 24'hABCDEF, 16'd4,      2'd1, 1'b0, 25'h0020000},
        '{1'b0, 5'd2,  5'd5,  16'd1, 8'h27, 8'h80, 8'h30, 24'h000001, 16'd1,      2'd2, 1'b0, 25'h0},
        '{1'b1, 5'd0,  5'd5,  16'd1, 8'h26, 8'h80, 8'hC8, 24'h000001, 16'd1,      2'd2, 1'b0, 25'h0},
        '{1'b1, 5'd4,  5'd0,  16'd1, 8'h27, 8'h80, 8'hEF, 24'h000000, 16'd0,      2'd2, 1'b0, 25'h0},
        '{1'b0, 5'd9,  5'd5,  16'd1, 8'h27, 8'h00, 8'hC8, 24'h000002, 16'd2,      2'd0, 1'b0, 25'h0},
        '{1'b0, 5'd4,  5'd16, 16'd7, 8'h27, 8'h80, 8'hCA, 24'hFFFFFF, 16'hFFFF,   2'd1, 1'b1, 25'h1FFFE00}
    };

    task automatic set_issue(input logic [0:0] p, input logic [NS-1:0] bits);
        issue_set_en   = 1'b1;
        issue_set_port = p;
        issue_set_bits = bits;
        @(negedge clk);
        issue_set_en   = 1'b0;
        issue_set_bits = '0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic put_header(input logic [0:0] p, input logic [4:0] s, input logic [31:0] opts, input logic [31:0] tbl);
        int a;
        a = (p ? 32'h400 : 32'h0) + 32 * int'(s);
        mem[a >> 2]       = opts;
        mem[(a >> 2) + 2] = tbl;
    endtask

    task automatic run_vec(input int i);
        vec_t        v;
        logic [31:0] hdr, tbl;
        logic [23:0] lba0;
        logic [24:0] by0;
        bit          saw, got;
        int          want_reads;
        v    = VECS[i];
        hdr  = (v.port ? 32'h400 : 32'h0) + 32 * int'(v.slot);
        tbl  = 32'h800 + 32'h40 * i;
        put_header(v.port, v.slot, {v.prdt, 11'b0, v.flen}, tbl);
        mem[tbl >> 2]       = {8'h00, v.b2, v.b1, v.b0};
        mem[(tbl >> 2) + 1] = {8'h00, v.lba};
        mem[(tbl >> 2) + 2] = 32'h0;
        mem[(tbl >> 2) + 3] = {16'h0, v.cnt};
        want_reads = 2 + ((v.flen > 5'd4) ? 4 : int'(v.flen));

        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        set_issue(v.port, NS'(1) << v.slot);
        pulse_start();

        saw = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 300 && !got; c++) begin
            if (retire_pulse) begin
                got = 1'b1;
                chk(bad_cmd == (v.kind == 2'd2), $sformatf("R8 vec%0d bad_cmd", i), 32'(bad_cmd), 32'(v.kind == 2'd2));
                chk(retire_port == v.port && retire_slot == v.slot, $sformatf("R9 vec%0d retire id", i),
                    {retire_port, retire_slot}, {v.port, v.slot});
                chk(rd_n == want_reads, $sformatf("R3 vec%0d frame reads", i), 32'(rd_n), 32'(want_reads));
                chk(rd_log[0] == hdr, $sformatf("R2 vec%0d options addr", i), rd_log[0], hdr);
                chk(rd_log[1] == hdr + 8, $sformatf("R2 vec%0d pointer addr", i), rd_log[1], hdr + 8);
                if (v.flen != 5'd0)
                    chk(rd_log[2] == tbl, $sformatf("R2 vec%0d frame addr", i), rd_log[2], tbl);
            end else if (mv_valid && !saw) begin
                saw = 1'b1;
                chk(mv_write == v.wr, $sformatf("R4 vec%0d direction", i), 32'(mv_write), 32'(v.wr));
                chk(mv_bytes == v.nbytes, $sformatf("R4 R5 vec%0d bytes", i), 32'(mv_bytes), 32'(v.nbytes));
                if (v.b2 != 8'hEC)
                    chk(mv_lba == v.lba, $sformatf("R4 vec%0d lba", i), 32'(mv_lba), 32'(v.lba));
                chk(mv_prdt_addr == tbl + 32'h80, $sformatf("R7 vec%0d list addr", i), mv_prdt_addr, tbl + 32'h80);
                chk(mv_prdt_cnt == v.prdt, $sformatf("R7 vec%0d list count", i), 32'(mv_prdt_cnt), 32'(v.prdt));
                chk(mv_port == v.port && mv_slot == v.slot, $sformatf("R9 vec%0d mover id", i),
                    {mv_port, mv_slot}, {v.port, v.slot});
                lba0 = mv_lba;
                by0  = mv_bytes;
                repeat (2) begin
                    @(negedge clk);
                    chk(mv_valid && mv_lba == lba0 && mv_bytes == by0 && !retire_pulse,
                        $sformatf("R11 vec%0d hold", i), 32'(mv_valid), 32'd1);
                end
                mv_done = 1'b1;
                @(negedge clk);
                mv_done = 1'b0;
                continue;
            end else begin
                @(negedge clk);
            end
        end
        chk(got, $sformatf("R11 vec%0d retired", i), 32'(got), 32'd1);
        chk(saw == (v.kind == 2'd1), $sformatf("R6 R8 vec%0d transfer seen", i), 32'(saw), 32'(v.kind == 2'd1));
        @(negedge clk);
        chk(issue_bits[int'(v.port) * NS + int'(v.slot)] == 1'b0, $sformatf("R10 vec%0d issue cleared", i),
            32'(issue_bits[int'(v.port) * NS + int'(v.slot)]), 32'd0);
        chk(irq_stat[v.port] == 1'b1, $sformatf("R10 vec%0d flag set", i), 32'(irq_stat), 32'(1 << v.port));
        chk(irq == (v.port == 1'b0), $sformatf("R10 vec%0d irq rollup", i), 32'(irq), 32'(v.port == 1'b0));
        irq_clr = 2'b11;
        @(negedge clk);
        irq_clr = 2'b00;
        chk(irq_stat == 2'b00 && !irq, $sformatf("R10 vec%0d flag clear", i), 32'(irq_stat), 32'd0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(issue_bits == '0, "R1 issue bits", 32'(issue_bits != '0), 32'd0);
        chk(irq_stat == '0 && !irq, "R1 flags", 32'(irq_stat), 32'd0);
        chk(!busy && !mem_req && !mv_valid && !retire_pulse, "R1 idle outputs",
            {busy, mem_req, mv_valid, retire_pulse}, 32'd0);

        // R9: empty request ends at once without reads
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        pulse_start();
        repeat (6) @(negedge clk);
        chk(!busy && rd_n == 0, "R9 empty scan", 32'(rd_n), 32'd0);

        // table of slot images
        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: ordering across ports and slots
        begin
            logic [5:0] order [4];
            int         n_ret;
            mem[32'hC00 >> 2] = {8'h00, 8'hEF, 8'h80, 8'h27};
            put_header(1'b0, 5'd5,  {16'd0, 11'b0, 5'd5}, 32'hC00);
            put_header(1'b0, 5'd12, {16'd0, 11'b0, 5'd5}, 32'hC00);
            put_header(1'b1, 5'd2,  {16'd0, 11'b0, 5'd5}, 32'hC00);
            set_issue(1'b1, NS'(1) << 2);
            set_issue(1'b0, (NS'(1) << 12) | (NS'(1) << 5));
            pulse_start();
            n_ret = 0;
            for (int c = 0; c < 400; c++) begin
                if (retire_pulse && n_ret < 4) begin
                    order[n_ret] = {retire_port, retire_slot};
                    n_ret++;
                end
                @(negedge clk);
            end
            chk(n_ret == 3, "R9 retire count", 32'(n_ret), 32'd3);
            chk(order[0] == {1'b0, 5'd5},  "R9 first",  32'(order[0]), 32'h05);
            chk(order[1] == {1'b0, 5'd12}, "R9 second", 32'(order[1]), 32'h0C);
            chk(order[2] == {1'b1, 5'd2},  "R9 third",  32'(order[2]), 32'h22);
            chk(!busy && issue_bits == '0, "R10 all retired", 32'(busy), 32'd0);
            chk(irq_stat == 2'b11 && irq, "R10 both flags", 32'(irq_stat), 32'h3);
            irq_en = 2'b00;
            @(negedge clk);
            chk(!irq, "R10 irq masked", 32'(irq), 32'd0);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule